// File: doc/BRIEF.md
# Factory Bad-Block Scanner

After a start pulse, this engine visits every erase block of a small-page NAND array. It looks for the factory marker that tags a block as unusable and records the result as one bit per block in an internal bitmap. It does not drive the flash pins. Each marker lookup goes as a single-byte read request to a command sequencer. The request carries a row (page) address and a column address. The sequencer answers with one byte and an acknowledge.

For each block, the engine reads the marker column of the block's first page. It reads the same column on the second page only when the first page shows the erased value FFh. Any other value on either page marks the block bad. Block 0 is always reported good and is never read. When the last block has been judged, a done flag rises and a count of bad blocks is valid. Any bitmap bit can then be read through a registered lookup port.

Top module: `nand_badblk_scan`

## Requirements
- R1: After reset, `scan_done` is 0, `bad_count` is 0 and `rd_req` is 0.
- R2: Block 0 is never requested (no request has a row below `PAGES`), and its bitmap bit reads 0 (good).
- R3: Every request has column `MARK_COL` (517). The first request for block b uses row b*PAGES. Blocks are visited in increasing order from 1 to NUM_BLOCKS-1.
- R4: When the byte returned for page 0 of a block is not FFh, the block's bitmap bit becomes 1. The next request is page 0 of the following block.
- R5: When page 0 returns FFh, the next request is row b*PAGES+1. The block is bad exactly when that byte is not FFh.
- R6: While `rd_req` is high and `rd_ack` is low, `rd_req`, `rd_row` and `rd_col` hold their values into the next cycle.
- R7: After the last block is judged, `scan_done` rises and stays high with `rd_req` low until the next accepted start. `bad_count` then equals the number of 1 bits in the bitmap and never exceeds NUM_BLOCKS.
- R8: A `start` pulse while a scan is running is ignored. The visiting order and the results are unchanged.
- R9: A `start` accepted when idle or done clears the bitmap and the count before the new scan. Stale bad bits from the previous scan do not survive.
- R10: `bm_bad` shows the bitmap bit selected by `bm_addr` one clock after `bm_addr` is applied (1 = bad).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| rd_req | output | 1 | Byte read request to the sequencer |
| rd_row | output | ROW_W (16) | Page address of the request |
| rd_col | output | COL_W (10) | Column address of the request |
| rd_ack | input | 1 | Sequencer completes the request this cycle |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| scan_done | output | 1 | Scan finished, results valid |
| bad_count | output | CNT_W (12) | Number of blocks found bad |
| bm_addr | input | BLK_W (11) | Block index for bitmap lookup |
| bm_bad | output | 1 | Registered bitmap bit for `bm_addr` |

## Verification
The hardest situations to reach are a start pulse landing in the middle of a long scan and a request held for several cycles before it is answered. A responder model answers every request after a random wait of zero to three cycles and checks that the address stays put during that wait. The bench injects a start pulse part way through one scan.

The marker bytes come from a seeded generator, so both the first-page and second-page failure paths occur hundreds of times per scan. One directed scan makes every marker FFh except the one on block 0, and makes the last block fail only on its second page. That scan proves block 0 is exempt, that bits from the previous scan are cleared, and that the final block is handled.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PG0  = 2'd1,
    ST_PG1  = 2'd2,
    ST_DONE = 2'd3
  } scan_st_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nbs_rowgen.sv
module nbs_rowgen #(
  parameter int BLK_W = 11,
  parameter int PG_W  = 5,
  parameter int ROW_W = BLK_W + PG_W
) (
  input  logic [BLK_W-1:0] blk,
  input  logic             second_pg,
  output logic [ROW_W-1:0] row
);
  logic [PG_W-1:0] pg_field;

  always_comb begin
    pg_field = '0;
    pg_field[0] = second_pg;
    row = {blk, pg_field};
  end
endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bits_d;
  logic             rd_d;

  always_comb begin
    bits_d = bits_q;
    if (clr) begin
      bits_d = '0;
    end else if (set_en) begin
      bits_d[set_idx] = 1'b1;
    end
    rd_d = bits_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      rd_bit <= 1'b0;
    end else begin
      if (clr || set_en) begin
        bits_q <= bits_d;
      end
      rd_bit <= rd_d;
    end
  end
endmodule

// File: rtl/nbs_satcnt.sv
module nbs_satcnt #(
  parameter int MAX = 2048,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CAP = W'(MAX);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt != CAP));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_badblk_scan.sv
module nand_badblk_scan #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGES      = 32,
  parameter int COL_W      = 10,
  parameter int MARK_COL   = 517,
  parameter int BLK_W      = $clog2(NUM_BLOCKS),
  parameter int PG_W       = $clog2(PAGES),
  parameter int ROW_W      = BLK_W + PG_W,
  parameter int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             scan_done,
  output logic [CNT_W-1:0] bad_count,
  input  logic [BLK_W-1:0] bm_addr,
  output logic             bm_bad
);
  import nbs_pkg::*;

  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);

  scan_st_t         st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             blk_en;
  logic             clr_res;
  logic             mark_bad;
  logic             marker_bad;

  always_comb begin
    st_d       = st_q;
    blk_d      = blk_q;
    blk_en     = 1'b0;
    clr_res    = 1'b0;
    mark_bad   = 1'b0;
    marker_bad = (rd_data != ERASED_BYTE);
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          clr_res = 1'b1;
          blk_en  = 1'b1;
          blk_d   = FIRST_BLK;
          st_d    = ST_PG0;
        end
      end
      ST_PG0: begin
        if (rd_ack) begin
          if (marker_bad) begin
            mark_bad = 1'b1;
            if (blk_q == LAST_BLK) begin
              st_d = ST_DONE;
            end else begin
              blk_en = 1'b1;
              blk_d  = blk_q + 1'b1;
            end
          end else begin
            st_d = ST_PG1;
          end
        end
      end
      ST_PG1: begin
        if (rd_ack) begin
          mark_bad = marker_bad;
          if (blk_q == LAST_BLK) begin
            st_d = ST_DONE;
          end else begin
            blk_en = 1'b1;
            blk_d  = blk_q + 1'b1;
            st_d   = ST_PG0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      blk_q <= '0;
    end else begin
      st_q <= st_d;
      if (blk_en) begin
        blk_q <= blk_d;
      end
    end
  end

  assign rd_req    = (st_q == ST_PG0) || (st_q == ST_PG1);
  assign rd_col    = COL_W'(MARK_COL);
  assign scan_done = (st_q == ST_DONE);

  nbs_rowgen #(
    .BLK_W(BLK_W),
    .PG_W (PG_W),
    .ROW_W(ROW_W)
  ) u_rowgen (
    .blk      (blk_q),
    .second_pg(st_q == ST_PG1),
    .row      (rd_row)
  );

  nbs_bitmap #(
    .DEPTH(NUM_BLOCKS),
    .AW   (BLK_W)
  ) u_bitmap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_res),
    .set_en (mark_bad),
    .set_idx(blk_q),
    .rd_addr(bm_addr),
    .rd_bit (bm_bad)
  );

  nbs_satcnt #(
    .MAX(NUM_BLOCKS),
    .W  (CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_res),
    .inc  (mark_bad),
    .cnt  (bad_count)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGES      = 32,
  parameter int COL_W      = 10,
  parameter int MARK_COL   = 517,
  parameter int BLK_W      = 11,
  parameter int PG_W       = 5,
  parameter int ROW_W      = 16,
  parameter int CNT_W      = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_req,
  input logic [ROW_W-1:0] rd_row,
  input logic [COL_W-1:0] rd_col,
  input logic             rd_ack,
  input logic             scan_done,
  input logic [CNT_W-1:0] bad_count
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_row) && $stable(rd_col)));

  // R3
  mark_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_col == COL_W'(MARK_COL)));

  // R2
  skip_blk0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_row >= ROW_W'(PAGES)));

  // R5
  two_pages_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_row[PG_W-1:1] == '0));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !rd_req);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !start) |=> scan_done);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_count <= CNT_W'(NUM_BLOCKS));
endmodule

bind nand_badblk_scan nbs_checker #(
  .NUM_BLOCKS(NUM_BLOCKS),
  .PAGES     (PAGES),
  .COL_W     (COL_W),
  .MARK_COL  (MARK_COL),
  .BLK_W     (BLK_W),
  .PG_W      (PG_W),
  .ROW_W     (ROW_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .rd_req   (rd_req),
  .rd_row   (rd_row),
  .rd_col   (rd_col),
  .rd_ack   (rd_ack),
  .scan_done(scan_done),
  .bad_count(bad_count)
);

// File: tb/sim_nand_badblk_scan.sv
`timescale 1ns/1ps
module sim_nand_badblk_scan;
  localparam int NB    = 2048;
  localparam int PG    = 32;
  localparam int MCOL  = 517;
  localparam int ROW_W = 16;
  localparam int COL_W = 10;
  localparam int BLK_W = 11;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             rd_req;
  logic [ROW_W-1:0] rd_row;
  logic [COL_W-1:0] rd_col;
  logic             rd_ack = 1'b0;
  logic [7:0]       rd_data = 8'h00;
  logic             scan_done;
  logic [CNT_W-1:0] bad_count;
  logic [BLK_W-1:0] bm_addr = '0;
  logic             bm_bad;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mk0 [NB];
  logic [7:0] mk1 [NB];
  bit         exp_bad [NB];

  int exp_blk;
  int exp_pg;
  int seq_err;
  int stab_err;
  bit scanning;

  always #4 clk = ~clk;

  nand_badblk_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .scan_done(scan_done), .bad_count(bad_count),
    .bm_addr(bm_addr), .bm_bad(bm_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit judge(input int b);
    if (b == 0) return 1'b0;
    return (mk0[b] != 8'hFF) || (mk1[b] != 8'hFF);
  endfunction

  function automatic int count_exp();
    int n = 0;
    for (int b = 0; b < NB; b++) n += exp_bad[b] ? 1 : 0;
    return n;
  endfunction

  // Responder: waits 0..3 cycles, checks hold, answers from mk0/mk1.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        automatic logic [ROW_W-1:0] r = rd_row;
        automatic logic [COL_W-1:0] c = rd_col;
        automatic int blk = int'(r) / PG;
        automatic int pg  = int'(r) % PG;
        automatic int dly = $urandom % 4;
        automatic int ex_row = exp_blk * PG + exp_pg;
        if (!scanning || int'(r) != ex_row || int'(c) != MCOL) begin
          if (seq_err == 0)
            $display("note: request row=%0d col=%0d expected row=%0d col=%0d",
                     r, c, ex_row, MCOL);
          seq_err++;
        end
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          if (!rd_req || rd_row != r || rd_col != c) stab_err++;
        end
        rd_data = (pg == 0) ? mk0[blk] : mk1[blk];
        rd_ack  = 1'b1;
        if (pg == 0 && mk0[blk] == 8'hFF) begin
          exp_pg = 1;
        end else begin
          exp_blk = exp_blk + 1;
          exp_pg  = 0;
        end
        @(negedge clk);
        rd_ack = 1'b0;
      end
    end
  end

  task automatic fill_random();
    for (int b = 0; b < NB; b++) begin
      mk0[b] = (($urandom % 8) == 0) ? 8'($urandom % 255) : 8'hFF;
      mk1[b] = (($urandom % 8) == 0) ? 8'($urandom % 255) : 8'hFF;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_scan(input string tag, input bit mid_start);
    for (int b = 0; b < NB; b++) exp_bad[b] = judge(b);
    exp_blk = 1; exp_pg = 0; seq_err = 0; stab_err = 0;
    @(negedge clk);
    scanning = 1'b1;
    pulse_start();
    if (mid_start) begin
      repeat (3000) @(negedge clk);
      chk(!scan_done && rd_req, "R8 scan still running", scan_done, 0);
      pulse_start();
    end
    while (!scan_done) @(negedge clk);
    scanning = 1'b0;
    chk(seq_err == 0, "R3/R4/R5 request order", seq_err, 0);
    if (mid_start) chk(seq_err == 0, "R8 order unchanged by start", seq_err, 0);
    chk(stab_err == 0, "R6 request held", stab_err, 0);
    chk(exp_blk == NB, "R3 all blocks visited", exp_blk, NB);
    chk(int'(bad_count) == count_exp(), "R7 bad count", bad_count, count_exp());
    repeat (20) @(negedge clk);
    chk(scan_done && !rd_req, "R7 done held, no request", scan_done, 1);
    begin
      int bm_err = 0;
      int first_bad_i = -1;
      for (int i = 0; i < NB; i++) begin
        bm_addr = BLK_W'(i);
        @(negedge clk);
        if (bm_bad != exp_bad[i]) begin
          bm_err++;
          if (first_bad_i < 0) first_bad_i = i;
        end
        if (i == 0) chk(bm_bad == 1'b0, "R2 block 0 good", bm_bad, 0);
      end
      if (first_bad_i >= 0)
        $display("note: first bitmap mismatch at block %0d", first_bad_i);
      chk(bm_err == 0, "R10/R4/R5 bitmap contents", bm_err, 0);
    end
    $display("scan %s: bad=%0d", tag, bad_count);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    scanning = 1'b0;
    exp_blk = 0; exp_pg = 0; seq_err = 0; stab_err = 0;
    repeat (3) @(negedge clk);
    chk(!scan_done, "R1 done after reset", scan_done, 0);
    chk(bad_count == 0, "R1 count after reset", bad_count, 0);
    chk(!rd_req, "R1 no request after reset", rd_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req && !scan_done, "R1 idle before start", rd_req, 0);

    fill_random();
    mk0[NB-1] = 8'h00;
    run_scan("random", 1'b0);

    fill_random();
    mk0[0] = 8'h00;
    run_scan("random+mid-start", 1'b1);

    for (int b = 0; b < NB; b++) begin
      mk0[b] = 8'hFF;
      mk1[b] = 8'hFF;
    end
    mk0[0] = 8'h00;
    mk1[0] = 8'h12;
    mk1[NB-1] = 8'hFE;
    run_scan("directed", 1'b0);
    chk(bad_count == 1, "R9 stale bits cleared", bad_count, 1);
    bm_addr = BLK_W'(NB-1);
    @(negedge clk);
    chk(bm_bad == 1'b1, "R5 last block second page", bm_bad, 1);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule